// File: doc/BRIEF.md
# Serial Converter Output Responder

This block stands in for the digital side of a 14-bit sampling converter with a three-wire serial read port. Host-side serial controllers can then be verified against synthesizable behaviour that follows the converter's pin timing. A one-cycle start request captures the sample value presented on `sample_i`. Busy is then raised for a programmable number of system clocks. When busy drops, the captured value is placed into a 16-bit output word with two leading zero bits.

The host reads the word with its own serial clock. The block samples that clock through a synchronizer and detects its edges in the system clock domain, so all of the logic runs on one clock. The first rising serial edge after a start enables the data line and presents the first bit. Each later falling edge moves the line on to the next bit. The falling edge after the last bit releases the line. A rising edge after that release begins a continuous re-read that repeats the word with no further release.

Top module: `adc_serial_responder`

## Requirements
- R1: After reset `busy_o` is 0 and `sdo_oe_o` is 0.
- R2: A high `conv_start_i` seen at a clock edge while not busy starts a conversion. `busy_o` rises at that edge and stays high for exactly `CONV_CYCLES` system clocks.
- R3: The result is the value on `sample_i` at the accepted start edge. Later changes of `sample_i` do not alter it. It enters the output word on the edge where `busy_o` falls.
- R4: A start request while `busy_o` is high is ignored. It neither lengthens busy nor replaces the captured value.
- R5: An accepted start releases the data line (`sdo_oe_o` = 0) and rewinds the read to word index 0. When a serial clock edge is detected in the same cycle, the start wins and the edge is discarded.
- R6: After a start, the first detected rising edge of `sclk_i` sets `sdo_oe_o` to 1 and drives word index 0. Falling edges seen before that first rise are ignored.
- R7: The word is sent as index 0 and index 1 equal to 0, then index 2+j equal to result bit 13-j (most significant bit first). Each detected falling edge advances one index, so the result's bit 0 (index 15) appears after the 15th falling edge. Rising edges while driving change nothing.
- R8: The 16th falling edge after the first rise sets `sdo_oe_o` to 0.
- R9: A rising edge after that release drives index 0 again with `sdo_oe_o` = 1. From then on, falling edges step through the word and wrap from index 15 to index 0. The line stays driven, including while the serial clock is stopped.
- R10: A level change on `sclk_i` takes effect on the outputs at the third system clock edge that samples the new level (a two-stage synchronizer plus one edge register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start_i | input | 1 | Conversion start request, sampled each clock |
| sample_i | input | 14 | Value taken as the conversion result |
| sclk_i | input | 1 | Host serial clock, asynchronous to clk |
| busy_o | output | 1 | Conversion in progress |
| sdo_o | output | 1 | Serial data; 0 when not enabled |
| sdo_oe_o | output | 1 | Data line drive enable (0 = high impedance) |

## Verification
An accepted conversion start and a detected serial clock edge can land in the same system clock cycle. The start must take priority so that the line goes to high impedance and the read rewinds. The bench provokes this case while the line is driven in its wrapping mode. It raises `sclk_i` exactly two clocks before it pulses `conv_start_i`, so that the synchronized rising edge is detected on the start cycle. It then checks that the enable is low, and that a later falling edge does not revive the line. It also checks that the next rising edge delivers the new word from index 0.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  // Data line state of the output shifter
  typedef enum logic [1:0] {
    LINE_ARMED  = 2'd0,  // rewound, high impedance, waits for the first rise
    LINE_SINGLE = 2'd1,  // first pass of the word, released at its end
    LINE_DONE   = 2'd2,  // word delivered, high impedance
    LINE_LOOP   = 2'd3   // re-read mode, wraps and stays driven
  } line_state_e;

  function automatic logic is_driving(line_state_e st);
    return (st == LINE_SINGLE) || (st == LINE_LOOP);
  endfunction

endpackage

// File: rtl/ssr_edge_sync.sv
module ssr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign level  = sync_q[STAGES-1];
  assign rise_o = level & ~last_q;
  assign fall_o = ~level & last_q;

endmodule

// File: rtl/ssr_conv_timer.sv
module ssr_conv_timer #(
  parameter int RES_BITS    = 14,
  parameter int CONV_CYCLES = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [RES_BITS-1:0] sample_i,
  output logic                go_o,
  output logic                done_o,
  output logic                busy_o,
  output logic [RES_BITS-1:0] result_o
);

  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;

  logic [CNT_W-1:0]    left_q;
  logic                busy_q;
  logic [RES_BITS-1:0] held_q;

  function automatic logic [CNT_W-1:0] span_init();
    return CNT_W'(CONV_CYCLES - 1);
  endfunction

  assign go_o   = start_i & ~busy_q;
  assign done_o = busy_q & (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
      held_q <= '0;
    end else if (go_o) begin
      busy_q <= 1'b1;
      left_q <= span_init();
      held_q <= sample_i;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign result_o = held_q;

endmodule

// File: rtl/ssr_out_shifter.sv
module ssr_out_shifter
  import ssr_pkg::*;
#(
  parameter int RES_BITS   = 14,
  parameter int LEAD_ZEROS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rewind_i,
  input  logic                load_i,
  input  logic [RES_BITS-1:0] result_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                sdo_o,
  output logic                oe_o
);

  localparam int WORD_BITS = RES_BITS + LEAD_ZEROS;
  localparam int PTR_W     = $clog2(WORD_BITS);
  localparam int LAST      = WORD_BITS - 1;

  line_state_e          st_q;
  logic [PTR_W-1:0]     ptr_q;
  logic [WORD_BITS-1:0] word_q;

  function automatic logic [WORD_BITS-1:0] frame(logic [RES_BITS-1:0] r);
    return {{LEAD_ZEROS{1'b0}}, r};
  endfunction

  function automatic logic at_end(logic [PTR_W-1:0] p);
    return p == PTR_W'(LAST);
  endfunction

  function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
    return at_end(p) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (load_i) word_q <= frame(result_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LINE_ARMED;
      ptr_q <= '0;
    end else if (rewind_i) begin
      st_q  <= LINE_ARMED;
      ptr_q <= '0;
    end else if (rise_i) begin
      case (st_q)
        LINE_ARMED: begin st_q <= LINE_SINGLE; ptr_q <= '0; end
        LINE_DONE:  begin st_q <= LINE_LOOP;   ptr_q <= '0; end
        default: ;
      endcase
    end else if (fall_i) begin
      case (st_q)
        LINE_SINGLE: begin
          if (at_end(ptr_q)) st_q <= LINE_DONE;
          else ptr_q <= step(ptr_q);
        end
        LINE_LOOP: ptr_q <= step(ptr_q);
        default: ;
      endcase
    end
  end

  assign oe_o  = is_driving(st_q);
  assign sdo_o = oe_o & word_q[PTR_W'(LAST) - ptr_q];

endmodule

// File: rtl/adc_serial_responder.sv
module adc_serial_responder #(
  parameter int RES_BITS    = 14,
  parameter int LEAD_ZEROS  = 2,
  parameter int CONV_CYCLES = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_start_i,
  input  logic [RES_BITS-1:0] sample_i,
  input  logic                sclk_i,
  output logic                busy_o,
  output logic                sdo_o,
  output logic                sdo_oe_o
);

  logic                conv_go;
  logic                load_evt;
  logic                sclk_rise;
  logic                sclk_fall;
  logic [RES_BITS-1:0] conv_result;

  ssr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (sclk_i),
    .rise_o  (sclk_rise),
    .fall_o  (sclk_fall)
  );

  ssr_conv_timer #(.RES_BITS(RES_BITS), .CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (conv_start_i),
    .sample_i (sample_i),
    .go_o     (conv_go),
    .done_o   (load_evt),
    .busy_o   (busy_o),
    .result_o (conv_result)
  );

  ssr_out_shifter #(.RES_BITS(RES_BITS), .LEAD_ZEROS(LEAD_ZEROS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .rewind_i (conv_go),
    .load_i   (load_evt),
    .result_i (conv_result),
    .rise_i   (sclk_rise),
    .fall_i   (sclk_fall),
    .sdo_o    (sdo_o),
    .oe_o     (sdo_oe_o)
  );

endmodule

// File: rtl/adc_serial_responder_chk.sv
module adc_serial_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_go,
  input logic load_evt,
  input logic sclk_rise,
  input logic sclk_fall,
  input logic busy_o,
  input logic sdo_o,
  input logic sdo_oe_o
);

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_o) |-> $past(conv_go)); // R2

  AST_LOAD_AT_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_o) |-> $past(load_evt)); // R3

  AST_START_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_n) conv_go |=> !sdo_oe_o); // R5

  AST_ENABLE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(sdo_oe_o) |-> $past(sclk_rise)); // R6

  AST_DATA_HOLDS_WITHOUT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe_o && $past(sdo_oe_o) && !$past(sclk_fall) && !$past(load_evt) && !$past(conv_go)) |-> $stable(sdo_o)); // R7

endmodule

bind adc_serial_responder adc_serial_responder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_go   (conv_go),
  .load_evt  (load_evt),
  .sclk_rise (sclk_rise),
  .sclk_fall (sclk_fall),
  .busy_o    (busy_o),
  .sdo_o     (sdo_o),
  .sdo_oe_o  (sdo_oe_o)
);

// File: tb/adc_serial_responder_tb.sv
module adc_serial_responder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CONV       = 20;
  localparam int WBITS      = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 1'b0;
  logic [13:0] sample = '0;
  logic        sclk = 1'b0;
  logic        busy, sdo, sdo_oe;
  int          checks = 0;
  int          fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_responder #(.CONV_CYCLES(CONV)) u_dut (
    .clk(clk), .rst_n(rst_n), .conv_start_i(conv_start), .sample_i(sample),
    .sclk_i(sclk), .busy_o(busy), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected level at word position idx: two zeros, then result MSB first
  function automatic int exp_bit(logic [13:0] v, int idx);
    if (idx < 2) return 0;
    return int'((v >> (WBITS - 1 - idx)) & 14'd1);
  endfunction

  task automatic set_sclk(logic v);
    @(negedge clk);
    sclk = v;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start_conv(logic [13:0] v);
    @(negedge clk);
    conv_start = 1'b1;
    sample = v;
    @(negedge clk);
    conv_start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  // one pass from a rise; loop=1 expects wrap instead of release
  task automatic read_word(logic [13:0] v, bit loop, string tag);
    set_sclk(1'b1);
    check({tag, " first rise enables"}, sdo_oe, 1);
    check({tag, " index 0"}, sdo, exp_bit(v, 0));
    for (int k = 1; k < WBITS; k++) begin
      set_sclk(1'b0);
      check("R7 data bit", sdo, exp_bit(v, k));
      check("R7 still driven", sdo_oe, 1);
      set_sclk(1'b1);
      check("R7 rise holds bit", sdo, exp_bit(v, k));
    end
    set_sclk(1'b0);
    if (!loop) check("R8 released after 16th fall", sdo_oe, 0);
    else begin
      check("R9 wraps driven", sdo_oe, 1);
      check("R9 wrap to index 0", sdo, exp_bit(v, 0));
    end
  endtask

  task automatic t_reset();
    check("R1 busy after reset", busy, 0);
    check("R1 enable after reset", sdo_oe, 0);
  endtask

  task automatic t_busy_and_capture();
    int n = 0;
    @(negedge clk);
    conv_start = 1'b1;
    sample = 14'h2AAA;
    @(negedge clk);
    conv_start = 1'b0;
    sample = 14'h1555;  // R3: change after the start edge
    while (busy) begin n++; @(negedge clk); end
    check("R2 busy length", n, CONV);
    read_word(14'h2AAA, 1'b0, "R3 R6");
  endtask

  task automatic t_ignore_busy();
    int n = 0;
    @(negedge clk);
    conv_start = 1'b1;
    sample = 14'h3FFF;
    @(negedge clk);
    conv_start = 1'b0;
    while (busy) begin
      n++;
      if (n == 3) begin conv_start = 1'b1; sample = 14'h0001; end
      else conv_start = 1'b0;
      @(negedge clk);
    end
    conv_start = 1'b0;
    check("R4 busy not extended", n, CONV);
    read_word(14'h3FFF, 1'b0, "R4");
  endtask

  task automatic t_latency();
    start_conv(14'h2001);
    sclk = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R10 not yet after two clocks", sdo_oe, 0);
    @(posedge clk); @(negedge clk);
    check("R10 enabled on third clock", sdo_oe, 1);
    check("R10 index 0 value", sdo, 0);
    set_sclk(1'b0);
    check("R7 second leading zero", sdo, 0);
  endtask

  task automatic t_restart();
    start_conv(14'h1234);
    read_word(14'h1234, 1'b0, "R6");
    read_word(14'h1234, 1'b1, "R9");
    repeat (40) @(negedge clk);
    check("R9 driven with clock stopped", sdo_oe, 1);
    set_sclk(1'b1);
    check("R9 rise in loop keeps data", sdo, exp_bit(14'h1234, 0));
    set_sclk(1'b0);
    check("R9 loop advances", sdo, exp_bit(14'h1234, 1));
  endtask

  task automatic t_collision();
    // line is driven in loop mode with sclk low
    @(negedge clk);
    sclk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    conv_start = 1'b1;
    sample = 14'h0F0F;
    @(negedge clk);
    conv_start = 1'b0;
    check("R5 start beats same-cycle rise", sdo_oe, 0);
    while (busy) @(negedge clk);
    set_sclk(1'b0);
    check("R6 fall before first rise ignored", sdo_oe, 0);
    read_word(14'h0F0F, 1'b0, "R5 rewound");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_busy_and_capture();
    t_ignore_busy();
    t_latency();
    t_restart();
    t_collision();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule